// File: doc/BRIEF.md
# Relay Frame Serial Transmitter

This block sends an 8-bit relay-state word to an external eight-channel relay driver over a write-only three-wire serial link. The three wires are an active-low chip select, a serial clock and a data line (MOSI). A word is handed over on a valid/ready handshake. The block then lowers chip select and clocks the eight bits out, starting with the bit for the highest relay. When the last bit is done it raises chip select again.

All timing comes from one parameter, the system-clock period in picoseconds. Each minimum interval the device needs is converted into a whole number of system-clock cycles by rounding up. Each interval is a separate parameter, so a chip with an unusual clock can override one of them directly. The serial clock idles low. Data is updated just after each falling serial-clock edge and holds steady across each rising edge, where the device samples it.

Top module: `relay_frame_tx`

## Requirements
- R1: While reset is asserted and whenever no frame is in progress, chip select is high, the serial clock is low, MOSI is low and ready is high.
- R2: A word is accepted on a rising system-clock edge where valid and ready are both high. Chip select goes low at that same edge. Ready stays low for as long as chip select is low.
- R3: Each frame has exactly 8 rising serial-clock edges. The first samples word bit 7 (relay 8) and the last samples bit 0 (relay 1).
- R4: MOSI never changes while the serial clock is high or at a rising edge. It is stable for at least 10 ns before and at least 10 ns after every rising edge.
- R5: The first rising serial-clock edge comes at least 10 ns after chip select falls. The first falling edge comes at least 80 ns after chip select falls.
- R6: Every serial-clock high phase lasts at least 60 ns, and every low phase between two bits lasts at least 60 ns.
- R7: Chip select rises at least 80 ns after the last falling serial-clock edge.
- R8: Each interval uses the smallest whole number of system-clock cycles that meets its minimum at CLK_PERIOD_PS. With a 10 ns clock, chip select stays low for exactly 100 cycles per frame (lead 2, high 6, low 6, tail 8).
- R9: A word presented with valid while a frame is in progress does not change the bits of that frame.
- R10: If valid is held high with a new word, the next frame starts exactly one cycle after chip select returns high.
- R11: A synchronous reset during a frame returns all outputs to the idle levels of R1 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A relay word is offered |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | DATA_W | Relay states; bit 7 is relay 8 |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the driver |

## Verification
Two situations are hard to create from the ports. The first is a request that arrives while a frame is already running: the bench holds valid high with a different word partway through a frame and lowers it before the frame ends. The second is a frame that starts with only a single idle cycle after the previous one: the bench keeps valid high across a frame boundary. In both cases it checks the gap and the sampled bits. The bench also sends all 256 relay words. It timestamps every chip-select edge, serial-clock edge and MOSI change in system-clock cycles and compares each interval against the nanosecond minimums.

// File: rtl/relay_tx_pkg.sv
// Package: shared state type and cycle-count helpers for the relay transmitter.
// Assumes: all times are given in picoseconds as positive integers.
package relay_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } tx_state_t;

    localparam int CS_TO_RISE_MIN_PS = 10000;
    localparam int CS_TO_FALL_MIN_PS = 80000;
    localparam int SCLK_HIGH_MIN_PS  = 60000;
    localparam int SCLK_LOW_MIN_PS   = 60000;
    localparam int TAIL_MIN_PS       = 80000;
    localparam int DATA_SETUP_MIN_PS = 10000;

    // Round a time up to whole clock cycles, never below one.
    function automatic int ps_to_cyc(input int t_ps, input int period_ps);
        int c;
        c = (t_ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    // Lead time: meet chip-select-to-rise, data setup, and chip-select-to-fall
    // (the latter given the high phase that follows the lead).
    function automatic int lead_cyc(input int period_ps, input int high_c);
        int c;
        c = ps_to_cyc(CS_TO_RISE_MIN_PS, period_ps);
        if (ps_to_cyc(DATA_SETUP_MIN_PS, period_ps) > c)
            c = ps_to_cyc(DATA_SETUP_MIN_PS, period_ps);
        if (ps_to_cyc(CS_TO_FALL_MIN_PS, period_ps) - high_c > c)
            c = ps_to_cyc(CS_TO_FALL_MIN_PS, period_ps) - high_c;
        return c;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/relay_phase_timer.sv
// Module: down-counter timing one phase of the serial frame.
// Assumes: load_val = phase length minus one; expired is high in the last
// cycle of the phase. The counter rests at zero when not loaded.
module relay_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_REST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/relay_shift_out.sv
// Module: MSB-first shift register that drives MOSI and tracks the bit index.
// Assumes: shift is pulsed once per serial-clock falling edge; zeros enter at
// the bottom, so MOSI returns low after the last shift.
module relay_shift_out #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    input  logic              shift,
    output logic              mosi,
    output logic              last_bit
);

    logic [DATA_W-1:0] sreg_q;
    logic [IDX_W-1:0]  idx_q;

    // Capture the word on load, otherwise move it up one bit per shift.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sreg_q <= '0;
        else if (load)
            sreg_q <= word;
        else if (shift)
            sreg_q <= {sreg_q[DATA_W-2:0], 1'b0};
    end

    // Count how many bits have already left the register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (load)
            idx_q <= '0;
        else if (shift)
            idx_q <= idx_q + 1'b1;
    end

    assign mosi     = sreg_q[DATA_W-1];
    assign last_bit = (idx_q == IDX_W'(DATA_W - 1));

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_W'(DATA_W)); // R3

endmodule

// File: rtl/relay_frame_tx.sv
// Module: top of the relay-driver serial transmitter.
// Accepts a word on valid/ready, then produces chip select, serial clock and
// MOSI with every interval counted in system-clock cycles.
// Assumes: CLK_PERIOD_PS is the real system-clock period; interval overrides
// must still meet the device minimums.
module relay_frame_tx #(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int DATA_W        = 8,
    parameter int HIGH_CYC = relay_tx_pkg::ps_to_cyc(relay_tx_pkg::SCLK_HIGH_MIN_PS, CLK_PERIOD_PS),
    parameter int LOW_CYC  = relay_tx_pkg::ps_to_cyc(relay_tx_pkg::SCLK_LOW_MIN_PS, CLK_PERIOD_PS),
    parameter int TAIL_CYC = relay_tx_pkg::ps_to_cyc(relay_tx_pkg::TAIL_MIN_PS, CLK_PERIOD_PS),
    parameter int LEAD_CYC = relay_tx_pkg::lead_cyc(CLK_PERIOD_PS, HIGH_CYC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              mosi_o
);
    import relay_tx_pkg::*;

    localparam int MAX_CYC = max4(HIGH_CYC, LOW_CYC, TAIL_CYC, LEAD_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int IDX_W   = $clog2(DATA_W + 1);

    tx_state_t        state_q, state_nx;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic             sh_load, sh_shift, sh_last;
    logic             cs_n_q, sclk_q;

    relay_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    relay_shift_out #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .word     (in_data),
        .shift    (sh_shift),
        .mosi     (mosi_o),
        .last_bit (sh_last)
    );

    // Next-state logic: walk lead, high/low bit phases and tail.
    always_comb begin
        state_nx = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state_q)
            ST_IDLE: if (in_valid) begin
                state_nx = ST_LEAD;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(LEAD_CYC - 1);
                sh_load  = 1'b1;
            end
            ST_LEAD: if (tmr_expired) begin
                state_nx = ST_HIGH;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(HIGH_CYC - 1);
            end
            ST_HIGH: if (tmr_expired) begin
                sh_shift = 1'b1;
                tmr_load = 1'b1;
                if (sh_last) begin
                    state_nx = ST_TAIL;
                    tmr_val  = CNT_W'(TAIL_CYC - 1);
                end else begin
                    state_nx = ST_LOW;
                    tmr_val  = CNT_W'(LOW_CYC - 1);
                end
            end
            ST_LOW: if (tmr_expired) begin
                state_nx = ST_HIGH;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(HIGH_CYC - 1);
            end
            ST_TAIL: if (tmr_expired) begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_nx;
    end

    // Registered line outputs, updated together with the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_n_q <= (state_nx == ST_IDLE);
            sclk_q <= (state_nx == ST_HIGH);
        end
    end

    assign cs_n_o   = cs_n_q;
    assign sclk_o   = sclk_q;
    assign in_ready = (state_q == ST_IDLE);

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o); // R1
    AST_MOSI_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !mosi_o); // R1
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !cs_n_o); // R2
    AST_MOSI_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(mosi_o)); // R4
    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R4

endmodule

// File: tb/relay_frame_tx_tb.sv
`timescale 1ns/1ps
module relay_frame_tx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int P_PS       = 10000;
    localparam int N_BITS     = 8;

    // Expected cycle counts from the nanosecond minimums (R8).
    localparam int HC   = (60000 + P_PS - 1) / P_PS;
    localparam int LC   = (60000 + P_PS - 1) / P_PS;
    localparam int TC   = (80000 + P_PS - 1) / P_PS;
    localparam int LD_A = (10000 + P_PS - 1) / P_PS;
    localparam int LD_B = (80000 + P_PS - 1) / P_PS - HC;
    localparam int LD   = (LD_A > LD_B) ? LD_A : LD_B;
    localparam int FRAME_LEN = LD + N_BITS * HC + (N_BITS - 1) * LC + TC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, cs_n_o, sclk_o, mosi_o;

    int total = 0;
    int bad = 0;

    relay_frame_tx #(.CLK_PERIOD_PS(P_PS), .DATA_W(N_BITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected-word queue filled at acceptance, drained at chip-select rise.
    logic [7:0] exp_mem [0:15];
    int wr_p = 0, rd_p = 0;
    bit skip_frame = 0;
    bit b2b_chk = 0;

    // Monitor state, all times in system-clock cycles.
    int cyc = 0;
    logic pcs = 1'b1, psclk = 1'b0, pmosi = 1'b0;
    int t_csf, t_csr = 0, nrise, nfall, first_rise, first_fall;
    int t_last_rise, t_last_fall, t_last_chg, min_hi, min_lo;
    int viol, rdy_viol, idle_viol;
    logic [7:0] bits;

    // Timestamp line events at the falling system edge and check each frame.
    always @(negedge clk) begin
        cyc++;
        if (pcs && !cs_n_o) begin
            t_csf = cyc; nrise = 0; nfall = 0; bits = 8'h00;
            min_hi = 1000000; min_lo = 1000000; viol = 0; rdy_viol = 0;
            t_last_chg = cyc; t_last_rise = cyc; t_last_fall = cyc;
            first_rise = cyc; first_fall = cyc;
            if (b2b_chk) chk((cyc - t_csr) == 1, "R10 gap", cyc - t_csr, 1);
        end
        if (!cs_n_o) begin
            if (!psclk && sclk_o) begin
                nrise++;
                bits = {bits[6:0], mosi_o};
                if (nrise == 1) first_rise = cyc;
                else if (cyc - t_last_fall < min_lo) min_lo = cyc - t_last_fall;
                if ((cyc - t_last_chg) * P_PS < 10000) viol++;
                t_last_rise = cyc;
            end
            if (psclk && !sclk_o) begin
                nfall++;
                if (nfall == 1) first_fall = cyc;
                if (cyc - t_last_rise < min_hi) min_hi = cyc - t_last_rise;
                t_last_fall = cyc;
            end
            if (mosi_o !== pmosi && !pcs) begin
                if (sclk_o) viol++;
                if (nrise > 0 && (cyc - t_last_rise) * P_PS < 10000) viol++;
                t_last_chg = cyc;
            end
            if (in_ready) rdy_viol++;
        end else if (rst_n) begin
            if (sclk_o || mosi_o || !in_ready) idle_viol++;
        end
        if (!pcs && cs_n_o) begin
            t_csr = cyc;
            if (skip_frame) begin
                skip_frame = 0;
                rd_p++;
            end else if (rd_p == wr_p) begin
                chk(0, "R2 unexpected frame", 1, 0);
            end else begin
                chk(nrise == N_BITS, "R3 rise count", nrise, N_BITS);
                chk(bits == exp_mem[rd_p % 16], "R3 bit order", bits, exp_mem[rd_p % 16]);
                chk((first_rise - t_csf) * P_PS >= 10000, "R5 cs to rise ps", (first_rise - t_csf) * P_PS, 10000);
                chk((first_fall - t_csf) * P_PS >= 80000, "R5 cs to fall ps", (first_fall - t_csf) * P_PS, 80000);
                chk(min_hi * P_PS >= 60000, "R6 high ps", min_hi * P_PS, 60000);
                chk(min_lo * P_PS >= 60000, "R6 low ps", min_lo * P_PS, 60000);
                chk((cyc - t_last_fall) * P_PS >= 80000, "R7 tail ps", (cyc - t_last_fall) * P_PS, 80000);
                chk(viol == 0, "R4 data timing", viol, 0);
                chk(rdy_viol == 0, "R2 ready low", rdy_viol, 0);
                chk((cyc - t_csf) == FRAME_LEN, "R8 frame cycles", cyc - t_csf, FRAME_LEN);
                chk(idle_viol == 0, "R1 idle levels", idle_viol, 0);
                rd_p++;
            end
        end
        pcs = cs_n_o; psclk = sclk_o; pmosi = mosi_o;
    end

    task automatic push(input logic [7:0] w);
        exp_mem[wr_p % 16] = w;
        wr_p++;
    endtask

    task automatic send_word(input logic [7:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        do @(negedge clk); while (cs_n_o);
        push(w);
        in_valid = 1'b0;
        do @(negedge clk); while (!cs_n_o);
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        idle_viol = 0;
        repeat (4) @(negedge clk);
        chk(cs_n_o == 1'b1, "R1 reset cs_n", cs_n_o, 1);
        chk(sclk_o == 1'b0, "R1 reset sclk", sclk_o, 0);
        chk(mosi_o == 1'b0, "R1 reset mosi", mosi_o, 0);
        chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n_o == 1'b1 && in_ready == 1'b1, "R1 idle after reset", cs_n_o, 1);

        // Full sweep of relay words (R3..R8).
        for (int w = 0; w < 256; w++) send_word(8'(w));

        // R9: competing request during a frame has no effect.
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'hA5;
        do @(negedge clk); while (cs_n_o);
        push(8'hA5);
        in_data = 8'h3C;
        repeat (20) @(negedge clk);
        chk(in_ready == 1'b0, "R9 busy ready", in_ready, 0);
        in_valid = 1'b0;
        do @(negedge clk); while (!cs_n_o);
        repeat (5) @(negedge clk);
        chk(cs_n_o == 1'b1, "R9 no extra frame", cs_n_o, 1);

        // R10: back-to-back frames with valid held high.
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'h81;
        do @(negedge clk); while (cs_n_o);
        push(8'h81);
        in_data = 8'h7E;
        do @(negedge clk); while (!cs_n_o);
        b2b_chk = 1;
        @(negedge clk);
        chk(cs_n_o == 1'b0, "R10 restart", cs_n_o, 0);
        push(8'h7E);
        b2b_chk = 0;
        in_valid = 1'b0;
        do @(negedge clk); while (!cs_n_o);

        // R11: reset in the middle of a frame.
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'hFF;
        do @(negedge clk); while (cs_n_o);
        push(8'hFF);
        in_valid = 1'b0;
        repeat (30) @(negedge clk);
        skip_frame = 1;
        rst_n = 1'b0;
        @(negedge clk);
        chk(cs_n_o == 1'b1, "R11 cs_n", cs_n_o, 1);
        chk(sclk_o == 1'b0, "R11 sclk", sclk_o, 0);
        chk(mosi_o == 1'b0, "R11 mosi", mosi_o, 0);
        chk(in_ready == 1'b1, "R11 ready", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        send_word(8'h5A);

        repeat (4) @(negedge clk);
        chk(rd_p == wr_p, "R2 frames drained", rd_p, wr_p);
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        summary();
        $finish;
    end

endmodule